// File: doc/BRIEF.md
# Effective Address Former

This unit turns a 16-bit instruction word into the memory address a data access should use. It is given the instruction, the already-incremented program counter, and one asynchronous register-file read port. On a start pulse it classifies the opcode and forms the address in one of three ways:

- **Program-counter relative:** a 9-bit signed field is added to the PC.
- **Base plus offset:** a 6-bit signed field is added to a general register.
- **Indirect:** the unit fetches a pointer word from memory, and that pointer becomes the address.

The load-effective-address opcode returns the PC-relative sum as a plain value and never touches memory.

The unit only forms the address. The load or store that follows is done by other logic. That logic uses the address, the value flag and the destination/source register index that this unit passes on.

For the indirect forms, the unit issues its own memory read request and holds it until read data returns. Only then does it signal completion. While it waits, further start pulses are dropped.

Top module: `ea_unit`

## Requirements
- R1: Opcodes 0010 and 0011 (bits 15:12) give result = pc_inc + sign-extended instr[8:0], with is_value=0 and unsupported=0. done is high in the cycle after the clock edge that sampled start.
- R2: Opcodes 0110 and 0111 drive reg_sel = instr[8:6] and give result = reg_data + sign-extended instr[5:0]. done follows one cycle after start.
- R3: Opcode 1110 gives result = pc_inc + sign-extended instr[8:0] with is_value=1. mem_req stays low.
- R4: Opcodes 1010 and 1011 raise mem_req from the cycle after start, with mem_addr = pc_inc + sign-extended instr[8:0]. mem_req and mem_addr are held until a clock edge samples mem_valid high. In the following cycle done=1, result = the mem_rdata sampled at that edge, and is_value=0.
- R5: Every other opcode (0000, 0001, 0100, 0101, 1000, 1001, 1100, 1101, 1111) gives done one cycle after start with unsupported=1, result=0, is_value=0 and no mem_req.
- R6: All address sums wrap modulo 2^16.
- R7: A start seen while an indirect read is outstanding is ignored. No extra done is produced, and the pending dst_idx and the final result are unchanged.
- R8: dst_idx equals instr[11:9] of the accepted instruction when done is high.
- R9: During and right after reset, done, mem_req, result, is_value, unsupported and dst_idx are all 0.
- R10: done is high for exactly one cycle for each accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin address formation for instr |
| instr | input | 16 | Instruction word |
| pc_inc | input | 16 | Incremented program counter |
| reg_sel | output | 3 | Register-file read index (instr[8:6]) |
| reg_data | input | 16 | Register-file read data |
| mem_req | output | 1 | Pointer read request, held until mem_valid |
| mem_addr | output | 16 | Pointer read address |
| mem_valid | input | 1 | Pointer read data valid |
| mem_rdata | input | 16 | Pointer read data |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Final address, or value for the LEA form |
| is_value | output | 1 | result is a value rather than an address |
| unsupported | output | 1 | Opcode has no addressing mode here |
| dst_idx | output | 3 | Register index instr[11:9] for the later access |

## Verification
Two functions can fall in the same cycle: a new start request, and a pending indirect read that is still waiting for its data. The bench provokes this by pulsing start with a load-effective-address instruction while mem_req is high and mem_valid is held low. It judges the outcome by three observations:

- done stays low while the read is outstanding.
- The completion that follows carries the pointer data, not the intruding sum.
- dst_idx still names the indirect instruction's register.

A second overlap is also tested: a start issued in the very cycle done is high. The bench checks that it is accepted and yields its own pulse.

// File: rtl/ea_pkg.sv
package ea_pkg;

  typedef enum logic [2:0] {
    EA_PCREL = 3'd0,
    EA_BASE  = 3'd1,
    EA_IND   = 3'd2,
    EA_LEA   = 3'd3,
    EA_BAD   = 3'd4
  } ea_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } ea_state_e;

  // Opcode classification; opcodes absent here have no addressing mode.
  function automatic ea_mode_e ea_classify(input logic [3:0] op);
    ea_mode_e m;
    case (op)
      4'b0010, 4'b0011: m = EA_PCREL;
      4'b0110, 4'b0111: m = EA_BASE;
      4'b1010, 4'b1011: m = EA_IND;
      4'b1110:          m = EA_LEA;
      default:          m = EA_BAD;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/ea_decode.sv
module ea_decode
  import ea_pkg::*;
(
  input  logic [3:0] opcode,
  output ea_mode_e   mode
);
  always_comb mode = ea_classify(opcode);
endmodule

// File: rtl/ea_offset_add.sv
module ea_offset_add #(
  parameter int W  = 16,
  parameter int OW = 9
) (
  input  logic [W-1:0]  base,
  input  logic [OW-1:0] ofs,
  output logic [W-1:0]  sum
);
  localparam int EXT_W = W - OW;

  function automatic logic [W-1:0] sext_add(input logic [W-1:0] b, input logic [OW-1:0] o);
    logic [W-1:0] ext;
    ext = {{EXT_W{o[OW-1]}}, o};
    return b + ext;
  endfunction

  always_comb sum = sext_add(base, ofs);
endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import ea_pkg::*;
#(
  parameter int W   = 16,
  parameter int RIW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  ea_mode_e       mode,
  input  logic [W-1:0]   pc_sum,
  input  logic [W-1:0]   base_sum,
  input  logic [RIW-1:0] dst_in,
  input  logic           mem_valid,
  input  logic [W-1:0]   mem_rdata,
  output logic           mem_req,
  output logic [W-1:0]   mem_addr,
  output logic           done,
  output logic [W-1:0]   result,
  output logic           is_value,
  output logic           unsupported,
  output logic [RIW-1:0] dst_idx
);
  ea_state_e    state;
  logic [W-1:0] ptr_q;
  logic         start_accept;
  logic         start_dropped;
  logic         ptr_return;

  assign start_accept  = start && (state == ST_IDLE);
  assign start_dropped = start && (state == ST_WAIT);
  assign ptr_return    = (state == ST_WAIT) && mem_valid;
  assign mem_req       = (state == ST_WAIT);
  assign mem_addr      = ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      ptr_q       <= '0;
      done        <= 1'b0;
      result      <= '0;
      is_value    <= 1'b0;
      unsupported <= 1'b0;
      dst_idx     <= '0;
    end else begin
      done <= 1'b0;
      if (start_accept) begin
        dst_idx     <= dst_in;
        is_value    <= 1'b0;
        unsupported <= 1'b0;
        case (mode)
          EA_PCREL: begin result <= pc_sum;   done <= 1'b1; end
          EA_BASE:  begin result <= base_sum; done <= 1'b1; end
          EA_LEA:   begin result <= pc_sum;   done <= 1'b1; is_value <= 1'b1; end
          EA_IND:   begin ptr_q  <= pc_sum;   state <= ST_WAIT; end
          default:  begin result <= '0;       done <= 1'b1; unsupported <= 1'b1; end
        endcase
      end else if (ptr_return) begin
        result <= mem_rdata;
        done   <= 1'b1;
        state  <= ST_IDLE;
      end
    end
  end

  // R9: reset clears the handshake outputs
  p_reset_quiet_r9: assert property (@(posedge clk) !rst_n |=> !done && !mem_req && result == '0);
  // R4: request and address held until data returns
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));
  // R7: nothing completes while the pointer is outstanding
  p_wait_no_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> !done);
  // R7: a dropped start leaves the pending register index alone
  p_drop_keeps_dst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_dropped |=> $stable(dst_idx));
  // R4: returned pointer completes as an address
  p_ptr_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_valid) |=> (done && !is_value && !mem_req && result == $past(mem_rdata)));
  // R5: unsupported completions carry no value or address
  p_unsup_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && unsupported) |-> (!is_value && result == '0));
endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int PCOFS_W = 9,
  parameter int BOFS_W  = 6,
  parameter int RIDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] instr,
  input  logic [DATA_W-1:0] pc_inc,
  output logic [RIDX_W-1:0] reg_sel,
  input  logic [DATA_W-1:0] reg_data,
  output logic              mem_req,
  output logic [DATA_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic [DATA_W-1:0] result,
  output logic              is_value,
  output logic              unsupported,
  output logic [RIDX_W-1:0] dst_idx
);
  localparam int OP_LSB  = DATA_W - 4;
  localparam int DST_LSB = OP_LSB - RIDX_W;
  localparam int SEL_LSB = DST_LSB - RIDX_W;

  ea_mode_e          mode;
  logic [DATA_W-1:0] pc_sum;
  logic [DATA_W-1:0] base_sum;

  assign reg_sel = instr[SEL_LSB +: RIDX_W];

  ea_decode u_dec (
    .opcode (instr[DATA_W-1:OP_LSB]),
    .mode   (mode)
  );

  ea_offset_add #(.W(DATA_W), .OW(PCOFS_W)) u_pc_add (
    .base (pc_inc),
    .ofs  (instr[PCOFS_W-1:0]),
    .sum  (pc_sum)
  );

  ea_offset_add #(.W(DATA_W), .OW(BOFS_W)) u_base_add (
    .base (reg_data),
    .ofs  (instr[BOFS_W-1:0]),
    .sum  (base_sum)
  );

  ea_ctrl #(.W(DATA_W), .RIW(RIDX_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .mode        (mode),
    .pc_sum      (pc_sum),
    .base_sum    (base_sum),
    .dst_in      (instr[DST_LSB +: RIDX_W]),
    .mem_valid   (mem_valid),
    .mem_rdata   (mem_rdata),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .done        (done),
    .result      (result),
    .is_value    (is_value),
    .unsupported (unsupported),
    .dst_idx     (dst_idx)
  );

  // R3: the value form never opens a memory request
  p_lea_no_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !mem_req && mode == EA_LEA) |=> !mem_req);
  // R5: an unsupported opcode never opens a memory request
  p_bad_no_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !mem_req && mode == EA_BAD) |=> (!mem_req && done && unsupported));
  // R1: direct forms complete in the following cycle
  p_one_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !mem_req && (mode == EA_PCREL || mode == EA_BASE)) |=> (done && !is_value));
endmodule

// File: tb/ea_unit_tb_top.sv
module ea_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;

  localparam logic [15:0] V_INSTR [NV] = '{16'h2605, 16'h3BFF, 16'h20FF, 16'h6443, 16'h7FA0,
                                           16'hE202, 16'hE900, 16'hA604, 16'hB1FE, 16'hC080};
  localparam logic [15:0] V_PC    [NV] = '{16'h3001, 16'h3000, 16'hFFF0, 16'h3000, 16'h3000,
                                           16'h3000, 16'h0100, 16'h3000, 16'h3000, 16'h3000};
  localparam logic [15:0] V_REG   [NV] = '{16'h0000, 16'h0000, 16'h0000, 16'h1000, 16'h0010,
                                           16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000};
  localparam logic [15:0] V_MEM   [NV] = '{16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000,
                                           16'h0000, 16'h0000, 16'h4000, 16'hABCD, 16'h0000};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [15:0] instr = '0, pc_inc = '0, mem_rdata = '0;
  logic mem_valid = 1'b0;
  logic [15:0] regs [8];
  logic [2:0] reg_sel, dst_idx;
  logic [15:0] reg_data, mem_addr, result;
  logic mem_req, done, is_value, unsupported;
  int checks = 0, errors = 0;
  bit finished = 0;

  assign reg_data = regs[reg_sel];
  always #(CLK_PERIOD/2) clk = ~clk;

  ea_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .pc_inc(pc_inc),
    .reg_sel(reg_sel), .reg_data(reg_data), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_valid(mem_valid), .mem_rdata(mem_rdata), .done(done), .result(result),
    .is_value(is_value), .unsupported(unsupported), .dst_idx(dst_idx)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Bench-side model: signed integer arithmetic, masked to 16 bits.
  function automatic logic [15:0] mdl_addr(input logic [15:0] ins, input logic [15:0] pc, input logic [15:0] rv);
    int off;
    int b;
    if (ins[15:12] == 4'b0110 || ins[15:12] == 4'b0111) begin
      off = int'($signed(ins[5:0]));
      b = int'(rv);
    end else begin
      off = int'($signed(ins[8:0]));
      b = int'(pc);
    end
    return 16'((b + off) & 32'hFFFF);
  endfunction

  function automatic int kind_of(input logic [3:0] op);
    // 0 direct address, 1 indirect, 2 value, 3 unsupported
    if (op == 4'h2 || op == 4'h3 || op == 4'h6 || op == 4'h7) return 0;
    if (op == 4'hA || op == 4'hB) return 1;
    if (op == 4'hE) return 2;
    return 3;
  endfunction

  task automatic run_op(input logic [15:0] ins, input logic [15:0] pc, input logic [15:0] rv,
                        input logic [15:0] md, input bit intrude);
    int k;
    logic [15:0] ea;
    k = kind_of(ins[15:12]);
    regs[ins[8:6]] = rv;
    ea = mdl_addr(ins, pc, rv);
    @(negedge clk);
    start = 1'b1; instr = ins; pc_inc = pc;
    @(negedge clk);
    start = 1'b0;
    if (k == 1) begin
      chk(mem_req == 1'b1, "R4 req", {15'b0, mem_req}, 16'h1);
      chk(mem_addr == ea, "R4 ptr addr", mem_addr, ea);
      chk(done == 1'b0, "R4 early done", {15'b0, done}, 16'h0);
      if (intrude) begin
        start = 1'b1; instr = 16'hE005; pc_inc = 16'h1234;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, "R7 intruding start done", {15'b0, done}, 16'h0);
        chk(mem_addr == ea, "R7 addr held", mem_addr, ea);
      end
      @(negedge clk);
      chk(mem_req == 1'b1 && mem_addr == ea, "R4 hold", mem_addr, ea);
      mem_valid = 1'b1; mem_rdata = md;
      @(negedge clk);
      mem_valid = 1'b0; mem_rdata = 16'hDEAD;
      chk(done == 1'b1, "R4 done", {15'b0, done}, 16'h1);
      chk(result == md, "R4 result", result, md);
      chk(is_value == 1'b0, "R4 is_value", {15'b0, is_value}, 16'h0);
      chk(dst_idx == ins[11:9], "R8 dst idx", {13'b0, dst_idx}, {13'b0, ins[11:9]});
    end else begin
      chk(done == 1'b1, "R1 done timing", {15'b0, done}, 16'h1);
      chk(mem_req == 1'b0, "R3 R5 no req", {15'b0, mem_req}, 16'h0);
      if (k == 3) begin
        chk(unsupported == 1'b1 && result == 16'h0, "R5 unsupported", result, 16'h0);
      end else begin
        chk(unsupported == 1'b0, "R1 unsupported clear", {15'b0, unsupported}, 16'h0);
        chk(result == ea, "R1 R2 R6 result", result, ea);
        chk(is_value == (k == 2), "R3 is_value", {15'b0, is_value}, {15'b0, k == 2});
      end
      chk(dst_idx == ins[11:9], "R8 dst idx", {13'b0, dst_idx}, {13'b0, ins[11:9]});
    end
    @(negedge clk);
    chk(done == 1'b0, "R10 single pulse", {15'b0, done}, 16'h0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) regs[i] = 16'h0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(done == 0 && mem_req == 0 && result == 0 && is_value == 0 && unsupported == 0 && dst_idx == 0,
        "R9 reset", result, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int v = 0; v < NV; v++) run_op(V_INSTR[v], V_PC[v], V_REG[v], V_MEM[v], 1'b0);
    // R7: start during outstanding pointer read
    run_op(16'hA7FE, 16'h0005, 16'h0, 16'h5A5A, 1'b1);
    // R5 / R1..R4: every opcode class
    for (int op = 0; op < 16; op++)
      run_op({op[3:0], 12'h2C1}, 16'h8000, 16'h7FFF, 16'h0F0F, 1'b0);
    // R10: back-to-back starts, second in the cycle done is high
    @(negedge clk);
    start = 1'b1; instr = 16'h2002; pc_inc = 16'h0010;
    @(negedge clk);
    instr = 16'h2E03;
    chk(done == 1'b1 && result == 16'h0012, "R10 first of pair", result, 16'h0012);
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1 && result == 16'h0013 && dst_idx == 3'd7, "R10 second of pair", result, 16'h0013);
    @(negedge clk);
    chk(done == 1'b0, "R10 pair ends", {15'b0, done}, 16'h0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule